// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

The block gathers interrupt requests from three external request pins and three internal timer event lines. It presents the most urgent one to a 68000-style processor as a three-bit priority level. Each source has its own control word, whose low three bits choose the priority level that source raises. A shared mask word blocks sources one by one. A rising edge on an external pin, or a single-cycle pulse on a timer line, sets a pending latch for that source. Once the source is unmasked and has a non-zero level, the latch is turned into a request on that level. At the same moment the vector number for the source is written into a per-level table.

When the processor acknowledges a level, the block returns the vector stored for that level and retires the level. A vector is built from the top three bits of a vector-base word plus a fixed code for the source: 0, 1 and 2 for the external pins, and 4, 5 and 6 for timers 0, 1 and 2. All control words, the mask, the vector base and an in-service word sit on a small 16-bit register bus. That bus is word-addressed and has byte-lane enables.

Top module: `vic_top`

## Requirements
- R1: While `rst` is high, the mask word becomes 0x07F7 and every other register becomes 0. All pending latches and active levels clear, and `ipl` is 0.
- R2: Mask bits 0..2 block external pins 0..2, and mask bits 8..10 block timers 0..2; a set bit blocks the source. A request that arrives while its source is blocked stays pending. It is issued in the cycle after the mask bit is cleared.
- R3: An external pin requests only on a 0-to-1 transition. A pin held high does not request again after it is served. Each cycle a timer line is high registers one timer event.
- R4: An issued vector equals {vbase[7:5], 5'b0} plus the source code. The code is 0, 1 or 2 for external pins 0..2 and 4, 5 or 6 for timers 0..2. Bits 4:0 of the vector-base word have no effect.
- R5: A source's level is bits 2:0 of its control word. The external control words sit at word addresses 0x40..0x42 and the timer control words at 0x47..0x49. A source whose level is 0 is never issued and keeps its pending latch until it is given a non-zero level.
- R6: One source is issued per cycle. Among the eligible sources the order is external 0, 1, 2, then timer 0, 1, 2. A stimulus sampled at clock edge N sets the pending latch at edge N, and the request becomes active at edge N+1.
- R7: `ipl` shows the highest active level, or 0 when none is active.
- R8: While `iack_valid` is high, `iack_vector` returns the vector stored for `iack_level` if that level is active, and 0x18 otherwise. The acknowledged level is retired at the clock edge that samples the acknowledge.
- R9: On a register write, `bus_be[0]` enables bits 7:0 and `bus_be[1]` enables bits 15:8. A lane that is not enabled keeps its old contents.
- R10: Register reads are combinational. The mask is at word address 0x4A, the in-service word at 0x4C and the vector base at 0x4D, and the control words are at the addresses in R5. All are 16-bit read/write. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_waddr | input | 9 | Register word address |
| bus_be | input | 2 | Byte-lane enables for writes |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_waddr` |
| ext_irq | input | 3 | External request pins, edge sensitive |
| tmr_irq | input | 3 | Timer event lines, one event per high cycle |
| ipl | output | 3 | Highest active priority level to the CPU |
| iack_valid | input | 1 | Acknowledge cycle in progress |
| iack_level | input | 3 | Level being acknowledged |
| iack_vector | output | 8 | Vector returned for the acknowledged level |

## Verification
A source event driven before edge N shows on `ipl` after edge N+1. When two sources fire together, the second one appears one edge later. A mask or control write that frees an already pending source shows on `ipl` one edge after the write edge. Reads and acknowledge vectors are combinational and are sampled a short delay after the inputs change. Retiring a level is observed on `ipl` right after the edge that took the acknowledge. The bench drives on falling edges, waits exactly these edge counts, and pushes each expectation into a scoreboard queue that the sampling task pops in order.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int NUM_EXT       = 3;
    localparam int NUM_TMR       = 3;
    localparam int NUM_SRC       = NUM_EXT + NUM_TMR;
    localparam int SRC_W         = $clog2(NUM_SRC);
    localparam int LVL_W         = 3;
    localparam int NUM_LVL       = 1 << LVL_W;
    localparam int VEC_W         = 8;
    localparam int VEC_LO_W      = 5;
    localparam int DATA_W        = 16;
    localparam int ADDR_W        = 9;
    localparam int TMR_MASK_LSB  = 8;
    localparam int TMR_CODE_BASE = 4;

    localparam logic [ADDR_W-1:0] WA_EXT_CTRL = 9'h040;
    localparam logic [ADDR_W-1:0] WA_TMR_CTRL = 9'h047;
    localparam logic [ADDR_W-1:0] WA_MASK     = 9'h04A;
    localparam logic [ADDR_W-1:0] WA_INSVC    = 9'h04C;
    localparam logic [ADDR_W-1:0] WA_VBASE    = 9'h04D;

    localparam logic [DATA_W-1:0] MASK_RST     = 16'h07F7;
    localparam logic [VEC_W-1:0]  SPURIOUS_VEC = 8'h18;

    typedef struct packed {
        logic             valid;
        logic [SRC_W-1:0] src;
        logic [LVL_W-1:0] lvl;
        logic [VEC_W-1:0] vec;
    } issue_t;

    function automatic int mask_bit(int idx);
        return (idx < NUM_EXT) ? idx : TMR_MASK_LSB + idx - NUM_EXT;
    endfunction

    function automatic logic [ADDR_W-1:0] ctrl_addr(int idx);
        return (idx < NUM_EXT) ? WA_EXT_CTRL + ADDR_W'(idx)
                               : WA_TMR_CTRL + ADDR_W'(idx - NUM_EXT);
    endfunction

    function automatic logic [VEC_LO_W-1:0] src_code(logic [SRC_W-1:0] s);
        return (int'(s) < NUM_EXT) ? VEC_LO_W'(s)
                                   : VEC_LO_W'(int'(s) - NUM_EXT + TMR_CODE_BASE);
    endfunction

    function automatic logic [DATA_W-1:0] lane_merge(logic [DATA_W-1:0] old_v,
                                                     logic [DATA_W-1:0] new_v,
                                                     logic [1:0] be);
        return {be[1] ? new_v[15:8] : old_v[15:8], be[0] ? new_v[7:0] : old_v[7:0]};
    endfunction
endpackage

// File: rtl/vic_regs.sv
module vic_regs
    import vic_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            wr_en,
    input  logic [ADDR_W-1:0]               waddr,
    input  logic [1:0]                      be,
    input  logic [DATA_W-1:0]               wdata,
    output logic [DATA_W-1:0]               rdata,
    output logic [NUM_SRC-1:0]              src_mask,
    output logic [VEC_W-1:VEC_LO_W]         vbase_hi,
    output logic [NUM_SRC-1:0][LVL_W-1:0]   src_lvl
);
    logic [DATA_W-1:0]              mask_q, insvc_q, vbase_q;
    logic [NUM_SRC-1:0][DATA_W-1:0] ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q  <= MASK_RST;
            insvc_q <= '0;
            vbase_q <= '0;
        end else if (wr_en) begin
            if (waddr == WA_MASK)  mask_q  <= lane_merge(mask_q, wdata, be);
            if (waddr == WA_INSVC) insvc_q <= lane_merge(insvc_q, wdata, be);
            if (waddr == WA_VBASE) vbase_q <= lane_merge(vbase_q, wdata, be);
        end
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_ctrl
        always_ff @(posedge clk) begin
            if (rst)
                ctrl_q[i] <= '0;
            else if (wr_en && waddr == ctrl_addr(i))
                ctrl_q[i] <= lane_merge(ctrl_q[i], wdata, be);
        end
        assign src_lvl[i]  = ctrl_q[i][LVL_W-1:0];
        assign src_mask[i] = mask_q[mask_bit(i)];
    end

    assign vbase_hi = vbase_q[VEC_W-1:VEC_LO_W];

    always_comb begin
        rdata = '0;
        if (waddr == WA_MASK)  rdata = mask_q;
        if (waddr == WA_INSVC) rdata = insvc_q;
        if (waddr == WA_VBASE) rdata = vbase_q;
        for (int i = 0; i < NUM_SRC; i++)
            if (waddr == ctrl_addr(i)) rdata = ctrl_q[i];
    end
endmodule

// File: rtl/vic_pend.sv
module vic_pend
    import vic_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_EXT-1:0]            ext_in,
    input  logic [NUM_TMR-1:0]            tmr_evt,
    input  logic [NUM_SRC-1:0]            src_mask,
    input  logic [NUM_SRC-1:0][LVL_W-1:0] src_lvl,
    input  logic [VEC_W-1:VEC_LO_W]       vbase_hi,
    output issue_t                        issue
);
    logic [NUM_EXT-1:0] ext_prev;
    logic [NUM_SRC-1:0] pend, evt, elig, clr;
    logic [SRC_W-1:0]   sel;

    assign evt = {tmr_evt, ext_in & ~ext_prev};

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_elig
        assign elig[i] = pend[i] & ~src_mask[i] & (src_lvl[i] != '0);
    end

    always_comb begin
        sel = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--)
            if (elig[i]) sel = SRC_W'(i);
    end

    assign clr = (|elig) ? (NUM_SRC'(1) << sel) : '0;

    always_comb begin
        issue.valid = |elig;
        issue.src   = sel;
        issue.lvl   = src_lvl[sel];
        issue.vec   = {vbase_hi, {VEC_LO_W{1'b0}}} + VEC_W'(src_code(sel));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ext_prev <= '0;
            pend     <= '0;
        end else begin
            ext_prev <= ext_in;
            pend     <= (pend & ~clr) | evt;
        end
    end
endmodule

// File: rtl/vic_levels.sv
module vic_levels
    import vic_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  issue_t             issue,
    input  logic               ack_valid,
    input  logic [LVL_W-1:0]   ack_level,
    output logic [LVL_W-1:0]   ipl,
    output logic [VEC_W-1:0]   ack_vector,
    output logic [NUM_LVL-1:0] act
);
    logic [NUM_LVL-1:0][VEC_W-1:0] vtab;

    always_ff @(posedge clk) begin
        if (rst) begin
            act  <= '0;
            vtab <= '0;
        end else begin
            if (ack_valid)
                act[ack_level] <= 1'b0;
            if (issue.valid) begin
                act[issue.lvl]  <= 1'b1;
                vtab[issue.lvl] <= issue.vec;
            end
        end
    end

    always_comb begin
        ipl = '0;
        for (int i = 1; i < NUM_LVL; i++)
            if (act[i]) ipl = LVL_W'(i);
    end

    assign ack_vector = act[ack_level] ? vtab[ack_level] : SPURIOUS_VEC;
endmodule

// File: rtl/vic_top.sv
module vic_top
    import vic_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_waddr,
    input  logic [1:0]          bus_be,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [NUM_EXT-1:0]  ext_irq,
    input  logic [NUM_TMR-1:0]  tmr_irq,
    output logic [LVL_W-1:0]    ipl,
    input  logic                iack_valid,
    input  logic [LVL_W-1:0]    iack_level,
    output logic [VEC_W-1:0]    iack_vector
);
    logic [NUM_SRC-1:0]            src_mask_w;
    logic [VEC_W-1:VEC_LO_W]       vbase_hi_w;
    logic [NUM_SRC-1:0][LVL_W-1:0] src_lvl_w;
    issue_t                        issue_w;
    logic [NUM_LVL-1:0]            act_w;

    vic_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(bus_we), .waddr(bus_waddr), .be(bus_be),
        .wdata(bus_wdata), .rdata(bus_rdata), .src_mask(src_mask_w),
        .vbase_hi(vbase_hi_w), .src_lvl(src_lvl_w)
    );

    vic_pend u_pend (
        .clk(clk), .rst(rst), .ext_in(ext_irq), .tmr_evt(tmr_irq),
        .src_mask(src_mask_w), .src_lvl(src_lvl_w), .vbase_hi(vbase_hi_w),
        .issue(issue_w)
    );

    vic_levels u_levels (
        .clk(clk), .rst(rst), .issue(issue_w), .ack_valid(iack_valid),
        .ack_level(iack_level), .ipl(ipl), .ack_vector(iack_vector), .act(act_w)
    );
endmodule

// File: rtl/vic_chk.sv
module vic_chk
    import vic_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic [LVL_W-1:0]   ipl,
    input logic [NUM_LVL-1:0] act,
    input issue_t             issue,
    input logic [NUM_SRC-1:0] src_mask,
    input logic               iack_valid,
    input logic [LVL_W-1:0]   iack_level,
    input logic [VEC_W-1:0]   iack_vector
);
    AST_MASK_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (src_mask == '1)); // R1

    AST_ISSUE_UNMASKED: assert property (@(posedge clk) disable iff (rst)
        issue.valid |-> !src_mask[issue.src]); // R2

    AST_ISSUE_LEVEL_NONZERO: assert property (@(posedge clk) disable iff (rst)
        issue.valid |-> (issue.lvl != '0)); // R5

    AST_VECTOR_CODE: assert property (@(posedge clk) disable iff (rst)
        iack_valid |-> (iack_vector == SPURIOUS_VEC ||
                        (iack_vector[4:3] == 2'b00 && iack_vector[2:0] != 3'd3))); // R4

    AST_IPL_IDLE: assert property (@(posedge clk) disable iff (rst)
        (act == '0) |-> (ipl == '0)); // R7

    AST_IPL_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        (ipl != '0) |-> act[ipl]); // R7

    AST_ACK_RETIRES: assert property (@(posedge clk) disable iff (rst)
        (iack_valid && iack_level != '0 && !(issue.valid && issue.lvl == iack_level))
        |=> !act[$past(iack_level)]); // R8
endmodule

bind vic_top vic_chk u_chk (
    .clk(clk), .rst(rst), .ipl(ipl), .act(act_w), .issue(issue_w),
    .src_mask(src_mask_w), .iack_valid(iack_valid), .iack_level(iack_level),
    .iack_vector(iack_vector)
);

// File: tb/tb_vic_top.sv
module tb_vic_top;
    import vic_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_waddr = '0;
    logic [1:0]        bus_be = 2'b00;
    logic [15:0]       bus_wdata = '0;
    logic [15:0]       bus_rdata;
    logic [2:0]        ext_irq = '0;
    logic [2:0]        tmr_irq = '0;
    logic [2:0]        ipl;
    logic              iack_valid = 1'b0;
    logic [2:0]        iack_level = '0;
    logic [7:0]        iack_vector;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    typedef struct {
        string       rid;
        string       what;
        logic [15:0] exp;
    } exp_t;
    exp_t sbq[$];

    always #2.5 clk = ~clk;

    vic_top dut (.*);

    task automatic tick(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_item(string rid, string what, logic [15:0] exp);
        exp_t e;
        e.rid = rid; e.what = what; e.exp = exp;
        sbq.push_back(e);
    endtask

    task automatic observe(logic [15:0] act);
        exp_t e;
        e = sbq.pop_front();
        checks++;
        if (act !== e.exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", e.rid, e.what, act, e.exp);
        end
    endtask

    task automatic wr(logic [ADDR_W-1:0] a, logic [15:0] d, logic [1:0] be = 2'b11);
        bus_we = 1'b1; bus_waddr = a; bus_wdata = d; bus_be = be;
        tick();
        bus_we = 1'b0; bus_be = 2'b00;
    endtask

    task automatic rd_check(string rid, logic [ADDR_W-1:0] a, logic [15:0] exp);
        bus_waddr = a;
        #1;
        expect_item(rid, "rdata", exp);
        observe(bus_rdata);
    endtask

    task automatic ipl_check(string rid, logic [2:0] exp);
        expect_item(rid, "ipl", 16'(exp));
        observe(16'(ipl));
    endtask

    task automatic ack_check(string rid, logic [2:0] lvl, logic [7:0] exp);
        iack_valid = 1'b1; iack_level = lvl;
        #1;
        expect_item(rid, "vector", 16'(exp));
        observe(16'(iack_vector));
        tick();
        iack_valid = 1'b0; iack_level = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst = 1'b0;
        tick();
        // R1 reset state
        ipl_check("R1", 3'd0);
        rd_check("R1", WA_MASK, 16'h07F7);
        rd_check("R1", WA_INSVC, 16'h0000);
        rd_check("R10", 9'h1FF, 16'h0000);

        wr(WA_VBASE, 16'h005F);              // top bits 010, low bits ignored (R4)
        wr(9'h040, 16'h0003);                // ext0 level 3
        wr(9'h041, 16'h0002);                // ext1 level 2
        wr(9'h042, 16'h0004);                // ext2 level 4
        wr(9'h048, 16'h0005);                // timer1 level 5
        wr(9'h049, 16'h0006);                // timer2 level 6
        rd_check("R10", 9'h048, 16'h0005);

        // R2 masked request stays pending
        ext_irq[0] = 1'b1; tick(); ext_irq[0] = 1'b0;
        tick(3);
        ipl_check("R2", 3'd0);
        wr(WA_MASK, 16'h07F6);
        tick();
        ipl_check("R2", 3'd3);
        ack_check("R4", 3'd3, 8'h40);
        ipl_check("R8", 3'd0);

        // R4 timer code 4+n
        wr(WA_MASK, 16'h05F6);
        tmr_irq[1] = 1'b1; tick(); tmr_irq[1] = 1'b0;
        tick();
        ipl_check("R6", 3'd5);
        ack_check("R4", 3'd5, 8'h45);

        // R6 ordering, R7 highest level
        wr(WA_MASK, 16'h01F4);
        ext_irq[1] = 1'b1; tmr_irq[2] = 1'b1; tick(); tmr_irq[2] = 1'b0;
        tick();
        ipl_check("R6", 3'd2);
        tick();
        ipl_check("R7", 3'd6);
        ack_check("R8", 3'd6, 8'h46);
        ipl_check("R7", 3'd2);
        ack_check("R8", 3'd2, 8'h41);
        // R3 held-high pin does not re-request
        tick(4);
        ipl_check("R3", 3'd0);
        ext_irq[1] = 1'b0;

        // R5 level 0 source waits
        wr(WA_MASK, 16'h00F4);
        tmr_irq[0] = 1'b1; tick(); tmr_irq[0] = 1'b0;
        tick(3);
        ipl_check("R5", 3'd0);
        wr(9'h047, 16'h0007);
        tick();
        ipl_check("R5", 3'd7);
        ack_check("R4", 3'd7, 8'h44);
        ack_check("R8", 3'd1, 8'h18);

        // R9 byte lanes
        wr(WA_MASK, 16'hAB07, 2'b01);
        rd_check("R9", WA_MASK, 16'h0007);
        wr(WA_MASK, 16'h0299, 2'b10);
        rd_check("R9", WA_MASK, 16'h0207);
        wr(WA_INSVC, 16'hA5C3);
        rd_check("R10", WA_INSVC, 16'hA5C3);

        // R1 reset clears pending
        ext_irq[2] = 1'b1; tick(); ext_irq[2] = 1'b0;
        tick(2);
        ipl_check("R2", 3'd0);
        rst = 1'b1; tick(2); rst = 1'b0;
        rd_check("R1", WA_MASK, 16'h07F7);
        rd_check("R1", 9'h048, 16'h0000);
        wr(9'h042, 16'h0004);
        wr(WA_MASK, 16'h0000);
        tick(3);
        ipl_check("R1", 3'd0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule